// File: doc/BRIEF.md
# SPI Controller Status Flag Unit

This block holds the status flags of an SPI controller and presents them as one 32-bit read-only word at register offset 0x10. The rest of the controller sends it single-cycle event strobes: enable and disable commands, writes to the transmit data register, moves of that data into the shifter, loads of the receive data register from the shifter, reads of the receive data register, a mode-fault detect, and the levels of shifter-idle and transfer-delay-done. It also watches the raw chip-select input, synchronizes it and records its rising edges.

Error and edge flags (mode fault, overrun, chip-select rise) are sticky and clear when the status word is read. A read returns the value held before that clear. When a set event meets a clearing read in the same cycle, the set wins, so no event is lost. The read port is combinational. It decodes one offset, returns zero for any other offset or when no read is requested, and raises a strobe whenever the status word is read.

Top module: `spi_status_unit`

## Requirements
- R1: The word carries the enable status at bit 16, transmit-empty at bit 9, chip-select rise at bit 8, overrun at bit 3, mode fault at bit 2, transmit-register-empty at bit 1 and receive-register-full at bit 0. Every other bit reads 0.
- R2: After reset the whole word is 0x00000000.
- R3: The enable bit is set by `en_cmd` and cleared by `dis_cmd`. When both arrive in the same cycle, disable wins.
- R4: Transmit-register-empty is 0 whenever the controller is disabled. It becomes 1 in the cycle after an enable command takes the controller from disabled to enabled.
- R5: While enabled, a transmit-register write clears transmit-register-empty and a transfer into the shifter sets it. If both occur in one cycle, the write wins.
- R6: Transmit-empty clears on a transmit-register write. It sets only when the controller is enabled, transmit-register-empty is 1, `shift_idle` is 1 and `delay_done` is 1.
- R7: `cs_in` passes through a two-stage synchronizer. A rising edge of the synchronized level sets the chip-select-rise flag, which holds until a status read.
- R8: Overrun sets when the receive register is loaded while receive-register-full is 1 and no receive-data read happens in the same cycle. It holds until a status read.
- R9: Mode fault sets on `modf_det` and holds until a status read.
- R10: Receive-register-full sets on a load from the shifter and clears on a receive-data read. A load wins over a read in the same cycle.
- R11: A status read clears the three sticky flags at the end of its cycle and returns their previous values. A set event in that same cycle leaves its flag set.
- R12: `rd_data` equals the status word and `stat_rd` is 1 when `rd_en` is 1 and `rd_addr` is 0x10. Otherwise `rd_data` is 0 and `stat_rd` is 0, and no flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_cmd | input | 1 | Enable command strobe |
| dis_cmd | input | 1 | Disable command strobe |
| tdr_wr | input | 1 | Transmit data register written |
| tdr_to_shift | input | 1 | Transmit data moved into the shifter |
| rdr_load | input | 1 | Receive data register loaded from the shifter |
| rdr_rd | input | 1 | Receive data register read |
| cs_in | input | 1 | Raw chip-select input level (idle high) |
| modf_det | input | 1 | Mode fault detected |
| shift_idle | input | 1 | Shifter holds no data |
| delay_done | input | 1 | Inter-transfer delay elapsed (held 1 when no delay is set) |
| rd_en | input | 1 | Register read request |
| rd_addr | input | ADDR_W | Register read offset |
| rd_data | output | 32 | Read data |
| stat_rd | output | 1 | Status word is being read this cycle |

## Verification
The bench builds the block with its default parameters: an 8-bit read offset, the status word at 0x10 and a two-stage chip-select synchronizer. With these values the exact three-edge latency from a `cs_in` rise to the flag can be counted. An offset next to the status word (0x14) can be used to show that a non-matching read neither returns data nor clears a flag. The shallow synchronizer lets one short low pulse on chip-select produce a flag within a few cycles. This leaves room in the run for the same-cycle collisions: set against clearing read, load against receive read, write against shifter transfer, and enable against disable.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
  localparam int STAT_W   = 32;
  localparam int POS_ENA  = 16;
  localparam int POS_TXE  = 9;
  localparam int POS_NSSR = 8;
  localparam int POS_OVR  = 3;
  localparam int POS_MODF = 2;
  localparam int POS_TDRE = 1;
  localparam int POS_RDRF = 0;

  typedef struct packed {
    logic ena;
    logic txe;
    logic csr;
    logic ovr;
    logic modf;
    logic tdre;
    logic rdrf;
  } stat_flags_t;

  // Set wins over clear; otherwise hold.
  function automatic logic sticky_next(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction

  function automatic logic [STAT_W-1:0] pack_status(stat_flags_t f);
    logic [STAT_W-1:0] w;
    w           = '0;
    w[POS_ENA]  = f.ena;
    w[POS_TXE]  = f.txe;
    w[POS_NSSR] = f.csr;
    w[POS_OVR]  = f.ovr;
    w[POS_MODF] = f.modf;
    w[POS_TDRE] = f.tdre;
    w[POS_RDRF] = f.rdrf;
    return w;
  endfunction

  function automatic logic [STAT_W-1:0] used_mask();
    stat_flags_t all;
    all = '1;
    return pack_status(all);
  endfunction
endpackage

// File: rtl/spi_stat_cs_edge.sv
module spi_stat_cs_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_in,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              lvl;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '1;
        else        sync_q <= cs_in;
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[STAGES-2:0], cs_in};
    end
  endgenerate

  assign lvl = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= lvl;

  assign rise_o = lvl & ~prev_q;
endmodule

// File: rtl/spi_stat_tx.sv
module spi_stat_tx (
  input  logic clk,
  input  logic rst_n,
  input  logic en_cmd,
  input  logic dis_cmd,
  input  logic tdr_wr,
  input  logic tdr_to_shift,
  input  logic shift_idle,
  input  logic delay_done,
  output logic ena_o,
  output logic tdre_o,
  output logic txe_o
);
  logic ena_q, tdre_q, txe_q;
  logic ena_d, tdre_d, txe_d;
  logic txe_set;

  always_comb begin
    ena_d = dis_cmd ? 1'b0 : (en_cmd ? 1'b1 : ena_q);
    if (!ena_d)            tdre_d = 1'b0;
    else if (!ena_q)       tdre_d = 1'b1;
    else if (tdr_wr)       tdre_d = 1'b0;
    else if (tdr_to_shift) tdre_d = 1'b1;
    else                   tdre_d = tdre_q;
  end

  assign txe_set = ena_q & tdre_q & shift_idle & delay_done;

  always_comb begin
    if (tdr_wr)       txe_d = 1'b0;
    else if (txe_set) txe_d = 1'b1;
    else              txe_d = txe_q;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ena_q  <= 1'b0;
      tdre_q <= 1'b0;
      txe_q  <= 1'b0;
    end else begin
      ena_q  <= ena_d;
      tdre_q <= tdre_d;
      txe_q  <= txe_d;
    end

  assign ena_o  = ena_q;
  assign tdre_o = tdre_q;
  assign txe_o  = txe_q;
endmodule

// File: rtl/spi_stat_rx.sv
module spi_stat_rx (
  input  logic clk,
  input  logic rst_n,
  input  logic rdr_load,
  input  logic rdr_rd,
  output logic rdrf_o,
  output logic ovr_evt_o
);
  import spi_stat_pkg::*;
  logic rdrf_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rdrf_q <= 1'b0;
    else        rdrf_q <= sticky_next(rdrf_q, rdr_load, rdr_rd);

  assign ovr_evt_o = rdr_load & rdrf_q & ~rdr_rd;
  assign rdrf_o    = rdrf_q;
endmodule

// File: rtl/spi_stat_sticky.sv
module spi_stat_sticky #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] flag_o
);
  import spi_stat_pkg::*;
  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= sticky_next(flag_q[i], set_i[i], clr_i);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/spi_status_unit.sv
module spi_status_unit #(
  parameter int              ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] STATUS_OFS = 8'h10,
  parameter int              SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_cmd,
  input  logic              dis_cmd,
  input  logic              tdr_wr,
  input  logic              tdr_to_shift,
  input  logic              rdr_load,
  input  logic              rdr_rd,
  input  logic              cs_in,
  input  logic              modf_det,
  input  logic              shift_idle,
  input  logic              delay_done,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              stat_rd
);
  import spi_stat_pkg::*;

  localparam int N_STICKY = 3;

  logic                ena, tdre, txe, rdrf;
  logic                cs_rise, ovr_evt;
  logic [N_STICKY-1:0] sticky_set, sticky_q;
  stat_flags_t         flags;
  logic [STAT_W-1:0]   stat_word;

  spi_stat_cs_edge #(.STAGES(SYNC_STAGES)) u_cs (
    .clk(clk), .rst_n(rst_n), .cs_in(cs_in), .rise_o(cs_rise)
  );

  spi_stat_tx u_tx (
    .clk(clk), .rst_n(rst_n), .en_cmd(en_cmd), .dis_cmd(dis_cmd),
    .tdr_wr(tdr_wr), .tdr_to_shift(tdr_to_shift), .shift_idle(shift_idle),
    .delay_done(delay_done), .ena_o(ena), .tdre_o(tdre), .txe_o(txe)
  );

  spi_stat_rx u_rx (
    .clk(clk), .rst_n(rst_n), .rdr_load(rdr_load), .rdr_rd(rdr_rd),
    .rdrf_o(rdrf), .ovr_evt_o(ovr_evt)
  );

  assign stat_rd    = rd_en && (rd_addr == STATUS_OFS);
  assign sticky_set = {cs_rise, ovr_evt, modf_det};

  spi_stat_sticky #(.N(N_STICKY)) u_sticky (
    .clk(clk), .rst_n(rst_n), .set_i(sticky_set), .clr_i(stat_rd),
    .flag_o(sticky_q)
  );

  always_comb begin
    flags.ena  = ena;
    flags.txe  = txe;
    flags.csr  = sticky_q[2];
    flags.ovr  = sticky_q[1];
    flags.modf = sticky_q[0];
    flags.tdre = tdre;
    flags.rdrf = rdrf;
  end

  assign stat_word = pack_status(flags);
  assign rd_data   = stat_rd ? stat_word : '0;
endmodule

// File: rtl/spi_status_unit_chk.sv
module spi_status_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en_cmd,
  input logic        dis_cmd,
  input logic        tdr_wr,
  input logic        tdr_to_shift,
  input logic        rdr_load,
  input logic        rdr_rd,
  input logic        modf_det,
  input logic        shift_idle,
  input logic        delay_done,
  input logic        rd_en,
  input logic        stat_rd,
  input logic        cs_rise,
  input logic [31:0] rd_data,
  input logic [31:0] stat_word
);
  import spi_stat_pkg::*;

  logic s_ena, s_txe, s_csr, s_ovr, s_modf, s_tdre, s_rdrf;
  assign s_ena  = stat_word[POS_ENA];
  assign s_txe  = stat_word[POS_TXE];
  assign s_csr  = stat_word[POS_NSSR];
  assign s_ovr  = stat_word[POS_OVR];
  assign s_modf = stat_word[POS_MODF];
  assign s_tdre = stat_word[POS_TDRE];
  assign s_rdrf = stat_word[POS_RDRF];

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_word & ~used_mask()) == '0); // R1
  AST_DIS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    dis_cmd |=> !s_ena); // R3
  AST_EN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    en_cmd && !dis_cmd |=> s_ena); // R3
  AST_TDRE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !s_ena |-> !s_tdre); // R4
  AST_TDRE_WR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    s_ena && !en_cmd && tdr_wr |=> !s_tdre); // R5
  AST_TDRE_XFER_SET: assert property (@(posedge clk) disable iff (!rst_n)
    s_ena && !dis_cmd && tdr_to_shift && !tdr_wr |=> s_tdre); // R5
  AST_TXE_WR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    tdr_wr |=> !s_txe); // R6
  AST_TXE_ROSE_COND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s_txe) |-> $past(s_tdre && shift_idle && delay_done)); // R6
  AST_NSSR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> s_csr); // R7
  AST_NSSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    s_csr && !stat_rd |=> s_csr); // R7
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rdr_load && s_rdrf && !rdr_rd |=> s_ovr); // R8
  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s_ovr) |-> $past(rdr_load && s_rdrf)); // R8
  AST_MODF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    modf_det |=> s_modf); // R9
  AST_RDRF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rdr_load |=> s_rdrf); // R10
  AST_RDRF_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    rdr_rd && !rdr_load |=> !s_rdrf); // R10
  AST_RD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !modf_det |=> !s_modf); // R11
  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rd_data == '0 && !stat_rd)); // R12
  AST_NO_SILENT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd && s_modf |=> s_modf); // R9
endmodule

bind spi_status_unit spi_status_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_cmd(en_cmd), .dis_cmd(dis_cmd),
  .tdr_wr(tdr_wr), .tdr_to_shift(tdr_to_shift), .rdr_load(rdr_load),
  .rdr_rd(rdr_rd), .modf_det(modf_det), .shift_idle(shift_idle),
  .delay_done(delay_done), .rd_en(rd_en), .stat_rd(stat_rd),
  .cs_rise(cs_rise), .rd_data(rd_data), .stat_word(stat_word)
);

// File: tb/spi_status_unit_tb.sv
`timescale 1ns/1ps
module spi_status_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en_cmd = 0, dis_cmd = 0, tdr_wr = 0, tdr_to_shift = 0;
  logic       rdr_load = 0, rdr_rd = 0, cs_in = 1, modf_det = 0;
  logic       shift_idle = 1, delay_done = 1, rd_en = 0;
  logic [7:0] rd_addr = 8'h00;
  logic [31:0] rd_data;
  logic        stat_rd;

  int checks = 0;
  int errors = 0;
  logic [31:0] last_rd;

  always #2 clk = ~clk;  // 250 MHz

  spi_status_unit u_dut (
    .clk(clk), .rst_n(rst_n), .en_cmd(en_cmd), .dis_cmd(dis_cmd),
    .tdr_wr(tdr_wr), .tdr_to_shift(tdr_to_shift), .rdr_load(rdr_load),
    .rdr_rd(rdr_rd), .cs_in(cs_in), .modf_det(modf_det),
    .shift_idle(shift_idle), .delay_done(delay_done), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .stat_rd(stat_rd)
  );

  // ---------------- reference model ----------------
  bit m_ena, m_tdre, m_txe, m_csr, m_ovr, m_modf, m_rdrf;
  bit cs_hist[$];

  function automatic logic [31:0] model_word();
    return (32'(m_ena) << 16) | (32'(m_txe) << 9) | (32'(m_csr) << 8) |
           (32'(m_ovr) << 3) | (32'(m_modf) << 2) | (32'(m_tdre) << 1) |
           32'(m_rdrf);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      {m_ena, m_tdre, m_txe, m_csr, m_ovr, m_modf, m_rdrf} <= '0;
      cs_hist = '{1'b1, 1'b1, 1'b1};
    end else begin
      bit hit, rise, n_ena;
      hit  = rd_en && rd_addr == 8'h10;
      rise = cs_hist[cs_hist.size()-2] && !cs_hist[cs_hist.size()-3];
      cs_hist.push_back(cs_in);
      void'(cs_hist.pop_front());
      n_ena = dis_cmd ? 1'b0 : (en_cmd ? 1'b1 : m_ena);
      m_ena <= n_ena;
      if (!n_ena)            m_tdre <= 0;
      else if (!m_ena)       m_tdre <= 1;
      else if (tdr_wr)       m_tdre <= 0;
      else if (tdr_to_shift) m_tdre <= 1;
      if (tdr_wr) m_txe <= 0;
      else if (m_ena && m_tdre && shift_idle && delay_done) m_txe <= 1;
      m_csr  <= rise ? 1'b1 : (hit ? 1'b0 : m_csr);
      m_ovr  <= (rdr_load && m_rdrf && !rdr_rd) ? 1'b1 : (hit ? 1'b0 : m_ovr);
      m_modf <= modf_det ? 1'b1 : (hit ? 1'b0 : m_modf);
      m_rdrf <= rdr_load ? 1'b1 : (rdr_rd ? 1'b0 : m_rdrf);
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Every-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    #1;
    begin
      logic hit;
      hit = rd_en && rd_addr == 8'h10;
      chk("R12 read data each cycle", rd_data, hit ? model_word() : 32'h0);
      chk("R12 read strobe each cycle", {31'b0, stat_rd}, {31'b0, hit});
      chk("R1 reserved bits zero", rd_data & ~32'h0001_030F, 32'h0);
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read();
    @(negedge clk);
    rd_en = 1; rd_addr = 8'h10;
    #1 last_rd = rd_data;
    @(negedge clk);
    rd_en = 0;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(3);
    do_read();
    chk("R2 reset value", last_rd, 32'h0);
    rst_n = 1;
    wait_cyc(2);
    do_read();
    chk("R2 value after reset release", last_rd, 32'h0);

    // R3 R4 R6: enable
    @(negedge clk); en_cmd = 1;
    @(negedge clk); en_cmd = 0;
    do_read();
    chk("R4 enable sets TDRE, R6 TXEMPTY, R3 enable bit", last_rd, 32'h0001_0202);

    // R5 R6: write then transfer, with delay
    @(negedge clk); tdr_wr = 1;
    @(negedge clk); tdr_wr = 0;
    do_read();
    chk("R5 write clears TDRE, R6 TXEMPTY clears", last_rd, 32'h0001_0000);
    @(negedge clk); tdr_to_shift = 1; shift_idle = 0; delay_done = 0;
    @(negedge clk); tdr_to_shift = 0;
    do_read();
    chk("R5 transfer sets TDRE", last_rd, 32'h0001_0002);
    @(negedge clk); shift_idle = 1;
    wait_cyc(3);
    do_read();
    chk("R6 TXEMPTY waits for delay", last_rd, 32'h0001_0002);
    @(negedge clk); delay_done = 1;
    do_read();
    chk("R6 TXEMPTY after delay", last_rd, 32'h0001_0202);

    // R5 write and transfer together: write wins
    @(negedge clk); tdr_wr = 1; tdr_to_shift = 1;
    @(negedge clk); tdr_wr = 0; tdr_to_shift = 0;
    do_read();
    chk("R5 write beats transfer", last_rd & 32'h2, 32'h0);
    @(negedge clk); tdr_to_shift = 1;
    @(negedge clk); tdr_to_shift = 0;
    wait_cyc(1);

    // R10 R8 R11: receive side
    @(negedge clk); rdr_load = 1;
    @(negedge clk); rdr_load = 0;
    do_read();
    chk("R10 load sets RDRF", last_rd, 32'h0001_0203);
    @(negedge clk); rdr_load = 1;
    @(negedge clk); rdr_load = 0;
    do_read();
    chk("R8 second load sets OVRES", last_rd, 32'h0001_020B);
    do_read();
    chk("R11 status read cleared OVRES", last_rd, 32'h0001_0203);
    @(negedge clk); rdr_load = 1; rdr_rd = 1;
    @(negedge clk); rdr_load = 0; rdr_rd = 0;
    do_read();
    chk("R8 load with read no overrun, R10 load wins", last_rd, 32'h0001_0203);
    @(negedge clk); rdr_rd = 1;
    @(negedge clk); rdr_rd = 0;
    do_read();
    chk("R10 read clears RDRF", last_rd, 32'h0001_0202);

    // R9 R11: mode fault
    @(negedge clk); modf_det = 1;
    @(negedge clk); modf_det = 0;
    wait_cyc(2);
    do_read();
    chk("R9 MODF sticky", last_rd, 32'h0001_0206);
    do_read();
    chk("R11 MODF cleared by read", last_rd, 32'h0001_0202);

    // R11 set wins over clearing read; read shows old value
    @(negedge clk); rd_en = 1; rd_addr = 8'h10; modf_det = 1;
    #1 last_rd = rd_data;
    chk("R11 read returns pre-clear value", last_rd, 32'h0001_0202);
    @(negedge clk); rd_en = 0; modf_det = 0;
    do_read();
    chk("R11 set wins over read", last_rd, 32'h0001_0206);
    do_read();

    // R7: chip-select rise, wrong-address read does not clear
    @(negedge clk); cs_in = 0;
    wait_cyc(4);
    @(negedge clk); cs_in = 1;
    wait_cyc(1);
    do_read();
    chk("R7 rise not yet through synchronizer", last_rd, 32'h0001_0202);
    wait_cyc(2);
    @(negedge clk); rd_en = 1; rd_addr = 8'h14;
    #1 chk("R12 other offset reads zero", rd_data, 32'h0);
    chk("R12 other offset no strobe", {31'b0, stat_rd}, 32'h0);
    @(negedge clk); rd_en = 0;
    do_read();
    chk("R7 NSSR set and kept", last_rd, 32'h0001_0302);
    do_read();
    chk("R7 NSSR cleared by read", last_rd, 32'h0001_0202);

    // R3 R4: enable and disable together
    @(negedge clk); en_cmd = 1; dis_cmd = 1;
    @(negedge clk); en_cmd = 0; dis_cmd = 0;
    do_read();
    chk("R3 disable wins, R4 TDRE off", last_rd & 32'h0001_0002, 32'h0);
    @(negedge clk); tdr_to_shift = 1;
    @(negedge clk); tdr_to_shift = 0;
    do_read();
    chk("R4 TDRE stays zero while disabled", last_rd & 32'h2, 32'h0);
    @(negedge clk); en_cmd = 1;
    @(negedge clk); en_cmd = 0;
    do_read();
    chk("R3 R4 re-enable", last_rd & 32'h0001_0002, 32'h0001_0002);

    wait_cyc(2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule